// File: doc/BRIEF.md
# Parallel-to-Serial Lane Serializer

This block turns a parallel word of 2 to 10 bits into a serial bit stream running on a fast clock. It runs either at single data rate or at double data rate. At single data rate it sends one bit per fast cycle. At double data rate it sends two bits per fast cycle. These two bits come out on a pair of registered outputs, one for the rising half of the fast cycle and one for the falling half, so the whole design stays in one clock edge. The mode and the word width are elaboration parameters. A combination that the block does not support stops elaboration.

Word capture is marked by a one-cycle load strobe in the fast clock domain. The strobe repeats once per word period: RATIO fast cycles at single data rate, RATIO/2 at double data rate. The first serial bit of a captured word does not come out after a plain shift-register depth. It comes out after a fixed latency that depends on both the mode and the ratio in a non-linear way. An output enable freezes the output registers without stopping the internal sequence. While it is low the block keeps advancing through the word, so those bits are not shown and are not held back for later.

Top module: `par2ser_lane`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `ser_rise` and `ser_fall` to 0. Both stay 0 until the first word that was loaded after reset is launched.
- R2: A load captures `din`. Bits leave in ascending index order: `din[0]` is the first serial bit and `din[RATIO-1]` is the last.
- R3: At single data rate, the first bit of a word reaches the output register at the Lth rising edge after the edge that samples `load`. L is 1, 3, 4, 4, 5, 5 and 6 for ratios 2, 3, 4, 5, 6, 7 and 8.
- R4: At double data rate, the first bit pair of a word reaches the outputs at the Lth rising edge after the load edge. L is 1, 3, 4 and 4 for ratios 4, 6, 8 and 10.
- R5: At single data rate, `ser_rise` carries one new bit per fast cycle and `ser_fall` stays 0.
- R6: At double data rate, in the k-th cycle of a word (k counting from 0), `ser_rise` carries `din[2k]` and `ser_fall` carries `din[2k+1]`.
- R7: While `oce` is low at an edge, both outputs keep their value. The word sequence still advances, so when `oce` returns high the output shows the bits scheduled for that edge.
- R8: When no word is being sent, both outputs hold the last bits they took.
- R9: Loads spaced exactly one word period apart produce a gapless stream. The launch of one word may fall on the same edge as the capture of the next.
- R10: A mode and ratio pair outside the supported sets stops elaboration. The supported sets are ratios 2 to 8 at single data rate and ratios 4, 6, 8 and 10 at double data rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe that captures `din` |
| din | input | RATIO | Parallel word; bit 0 is sent first |
| oce | input | 1 | Output enable; while low the output registers hold |
| ser_rise | output | 1 | Serial bit (single data rate) or rising-half bit (double data rate) |
| ser_fall | output | 1 | Falling-half bit at double data rate; 0 at single data rate |

## Verification
The bench runs six configurations: the narrowest and widest ratios of each mode, plus the odd-latency points at ratios 3 and 6. The latency corners are the main target. A design that used one shift depth for every ratio would be off by one or more cycles on at least one of the configurations, and it would fail on every bit. Sequences with the enable toggled on random cycles catch a design that stalls the word while the enable is low. Such a design would show stale or repeated bits after the enable returns. Back-to-back loads catch a design that corrupts the word captured on the same edge as a launch. Idle gaps and a mid-run reset catch a design that leaks old bits, or shows non-zero output before the first launch.

// File: rtl/par2ser_pkg.sv
package par2ser_pkg;

  // Elaboration-time check of the mode/ratio pair.
  function automatic bit cfg_supported(bit ddr, int ratio);
    if (ddr) return (ratio == 4) || (ratio == 6) || (ratio == 8) || (ratio == 10);
    return (ratio >= 2) && (ratio <= 8);
  endfunction

  // Bits emitted per fast-clock cycle.
  function automatic int lanes_of(bit ddr);
    return ddr ? 2 : 1;
  endfunction

  // Fast cycles per word period.
  function automatic int steps_of(bit ddr, int ratio);
    return ratio / lanes_of(ddr);
  endfunction

  // Fast-clock edges from the load edge to the edge that registers bit 0.
  function automatic int latency_of(bit ddr, int ratio);
    int lat;
    lat = 1;
    if (ddr) begin
      case (ratio)
        6:       lat = 3;
        8, 10:   lat = 4;
        default: lat = 1;
      endcase
    end else begin
      case (ratio)
        3:       lat = 3;
        4, 5:    lat = 4;
        6, 7:    lat = 5;
        8:       lat = 6;
        default: lat = 1;
      endcase
    end
    return lat;
  endfunction

endpackage

// File: rtl/par2ser_capture.sv
module par2ser_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (load) word_q <= din;
  end
endmodule

// File: rtl/par2ser_delay.sv
module par2ser_delay #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic strobe_out
);
  logic [DEPTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= 1'b0;
    else     stage_q[0] <= strobe_in;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[i] <= 1'b0;
      else     stage_q[i] <= stage_q[i-1];
    end
  end

  assign strobe_out = stage_q[DEPTH-1];
endmodule

// File: rtl/par2ser_shift.sv
module par2ser_shift #(
  parameter int W     = 8,
  parameter int LANES = 1,
  parameter int STEPS = 8,
  localparam int CW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [W-1:0]  word,
  input  logic          oce,
  output logic          ser_rise,
  output logic          ser_fall,
  output logic          emit,
  output logic [CW-1:0] step_cnt
);
  logic [W-1:0]     sh_q;
  logic [LANES-1:0] group;
  logic             more;

  assign more  = (step_cnt != '0);
  assign emit  = launch | more;
  assign group = launch ? word[LANES-1:0] : sh_q[LANES-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      step_cnt <= '0;
    end else if (launch) begin
      sh_q     <= {{LANES{1'b0}}, word[W-1:LANES]};
      step_cnt <= CW'(STEPS - 1);
    end else if (more) begin
      sh_q     <= {{LANES{1'b0}}, sh_q[W-1:LANES]};
      step_cnt <= step_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              ser_rise <= 1'b0;
    else if (emit && oce) ser_rise <= group[0];
  end

  if (LANES == 2) begin : g_ddr
    always_ff @(posedge clk) begin
      if (rst)              ser_fall <= 1'b0;
      else if (emit && oce) ser_fall <= group[LANES-1];
    end
  end else begin : g_sdr
    assign ser_fall = 1'b0;
  end
endmodule

// File: rtl/par2ser_lane.sv
module par2ser_lane
  import par2ser_pkg::*;
#(
  parameter bit DDR   = 1'b0,
  parameter int RATIO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RATIO-1:0] din,
  input  logic             oce,
  output logic             ser_rise,
  output logic             ser_fall
);
  localparam int LANES = lanes_of(DDR);
  localparam int STEPS = steps_of(DDR, RATIO);
  localparam int LAT   = latency_of(DDR, RATIO);
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  // R10: reject unsupported configurations at elaboration
  if (!cfg_supported(DDR, RATIO)) begin : g_bad_cfg
    $error("par2ser_lane: unsupported mode/ratio pair");
  end

  logic [RATIO-1:0] word_q;
  logic             launch;
  logic             emit;
  logic [CW-1:0]    step_cnt;

  par2ser_capture #(.W(RATIO)) u_capture (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .din    (din),
    .word_q (word_q)
  );

  par2ser_delay #(.DEPTH(LAT)) u_delay (
    .clk        (clk),
    .rst        (rst),
    .strobe_in  (load),
    .strobe_out (launch)
  );

  par2ser_shift #(.W(RATIO), .LANES(LANES), .STEPS(STEPS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .word     (word_q),
    .oce      (oce),
    .ser_rise (ser_rise),
    .ser_fall (ser_fall),
    .emit     (emit),
    .step_cnt (step_cnt)
  );
endmodule

// File: rtl/par2ser_lane_chk.sv
module par2ser_lane_chk
  import par2ser_pkg::*;
#(
  parameter bit DDR   = 1'b0,
  parameter int RATIO = 8,
  localparam int STEPS = steps_of(DDR, RATIO),
  localparam int LAT   = latency_of(DDR, RATIO),
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic          oce,
  input logic          ser_rise,
  input logic          ser_fall,
  input logic          launch,
  input logic          emit,
  input logic [CW-1:0] step_cnt
);
  logic seen_launch;

  always_ff @(posedge clk) begin
    if (rst)         seen_launch <= 1'b0;
    else if (launch) seen_launch <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ser_rise == 1'b0 && ser_fall == 1'b0)); // R1

  AST_QUIET_BEFORE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    !seen_launch |-> (ser_rise == 1'b0 && ser_fall == 1'b0)); // R1

  AST_LAUNCH_LATENCY: assert property (@(posedge clk) disable iff (rst)
    launch |-> $past(load, LAT)); // R3 R4

  AST_WORD_CONTINUES: assert property (@(posedge clk) disable iff (rst)
    launch |=> (emit && step_cnt != '0)); // R2

  AST_SDR_FALL_LOW: assert property (@(posedge clk) disable iff (rst)
    !DDR |-> (ser_fall == 1'b0)); // R5

  AST_OCE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !oce |=> ($stable(ser_rise) && $stable(ser_fall))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !emit |=> ($stable(ser_rise) && $stable(ser_fall))); // R8
endmodule

bind par2ser_lane par2ser_lane_chk #(.DDR(DDR), .RATIO(RATIO)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .oce      (oce),
  .ser_rise (ser_rise),
  .ser_fall (ser_fall),
  .launch   (launch),
  .emit     (emit),
  .step_cnt (step_cnt)
);

// File: tb/tb_par2ser_lane.sv
module tb_par2ser_harness #(
  parameter bit DDR   = 1'b0,
  parameter int RATIO = 8
) (
  input  logic clk,
  output int   checks,
  output int   fails,
  output bit   done
);
  // Independent restatement of the latency table: index = ratio
  localparam int SDR_LAT [0:8]  = '{0, 0, 1, 3, 4, 4, 5, 5, 6};
  localparam int DDR_LAT [0:10] = '{0, 0, 0, 0, 1, 0, 3, 0, 4, 0, 4};
  localparam int LAT  = DDR ? DDR_LAT[RATIO] : SDR_LAT[RATIO];
  localparam int BPC  = DDR ? 2 : 1;
  localparam int PER  = RATIO / BPC;

  typedef struct { int due; bit r; bit f; } ent_t;

  logic             rst, load, oce;
  logic [RATIO-1:0] din;
  logic             ser_rise, ser_fall;

  par2ser_lane #(.DDR(DDR), .RATIO(RATIO)) dut (
    .clk(clk), .rst(rst), .load(load), .din(din), .oce(oce),
    .ser_rise(ser_rise), .ser_fall(ser_fall)
  );

  ent_t  pend[$];
  int    n = 0;
  bit    exp_r = 0, exp_f = 0;
  string tag = "R1";
  bit    rand_oce = 0;

  // Behavioural reference: schedule each word's bits at absolute edge numbers.
  always @(posedge clk) begin
    n = n + 1;
    if (rst) begin
      exp_r = 0; exp_f = 0;
      pend.delete();
    end else begin
      if (pend.size() > 0 && pend[0].due == n) begin
        ent_t e;
        e = pend.pop_front();
        if (oce) begin exp_r = e.r; exp_f = e.f; end
      end
      if (load) begin
        for (int i = 0; i < PER; i++) begin
          ent_t e;
          e.due = n + LAT + i;
          e.r   = din[i*BPC];
          e.f   = DDR ? din[i*BPC + BPC - 1] : 1'b0;
          pend.push_back(e);
        end
      end
    end
  end

  // Compare on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (n == 1) begin
      for (int r = 1; r <= 11; r++) begin
        for (int m = 0; m < 2; m++) begin
          bit want;
          bit got;
          want = (m == 1) ? (r % 2 == 0 && r >= 4 && r <= 10) : (r > 1 && r < 9);
          got  = par2ser_pkg::cfg_supported(m[0], r);
          checks = checks + 1;
          if (got != want) begin
            fails = fails + 1;
            $display("FAIL R10 support ddr=%0d ratio=%0d: got %0d expected %0d", m, r, got, want);
          end
        end
      end
    end
    if (n >= 1) begin
      checks = checks + 1;
      if (ser_rise !== exp_r || ser_fall !== exp_f) begin
        fails = fails + 1;
        $display("FAIL %s ddr=%0d ratio=%0d edge %0d: got rise/fall %b%b expected %b%b",
                 tag, DDR, RATIO, n, ser_rise, ser_fall, exp_r, exp_f);
      end
    end
  end

  task automatic send(input logic [RATIO-1:0] w, input int gap);
    load = 1'b1; din = w;
    if (rand_oce) oce = $urandom_range(0, 1);
    @(negedge clk);
    load = 1'b0;
    for (int c = 0; c < PER - 1 + gap; c++) begin
      if (rand_oce) oce = $urandom_range(0, 1);
      @(negedge clk);
    end
  endtask

  task automatic drain();
    repeat (LAT + PER + 2) @(negedge clk);
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    rst = 1; load = 0; oce = 1; din = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    // R1 then R3/R4: first word after reset, lone
    tag = DDR ? "R4" : "R3";
    send({RATIO{1'b1}}, 5);
    drain();
    // R2: walking one, bit order
    tag = "R2";
    for (int b = 0; b < RATIO; b++) send(RATIO'(1) << b, 0);
    drain();
    // R5 / R6 with random words, back-to-back
    tag = DDR ? "R6" : "R5";
    for (int k = 0; k < 12; k++) send(RATIO'($urandom), 0);
    // R9: alternating patterns, gapless
    tag = "R9";
    for (int k = 0; k < 8; k++) send(k[0] ? {RATIO/2{2'b10}} : ~RATIO'(0) ^ RATIO'(k), 0);
    drain();
    // R7: random output enable
    tag = "R7";
    rand_oce = 1;
    for (int k = 0; k < 16; k++) send(RATIO'($urandom), 0);
    rand_oce = 0; oce = 1;
    drain();
    // R8: gaps between words, outputs hold
    tag = "R8";
    for (int k = 0; k < 6; k++) send(RATIO'($urandom), 3 + k);
    drain();
    // R1: mid-run reset, then quiet until launch
    tag = "R1";
    send(RATIO'($urandom), 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    send({RATIO{1'b1}}, 0);
    drain();
    done = 1;
  end
endmodule

module tb_par2ser_lane;
  logic clk = 0;
  always #5 clk = ~clk;

  int c0, c1, c2, c3, c4, c5;
  int f0, f1, f2, f3, f4, f5;
  bit d0, d1, d2, d3, d4, d5;

  tb_par2ser_harness #(.DDR(1'b0), .RATIO(2))  h_s2  (.clk(clk), .checks(c0), .fails(f0), .done(d0));
  tb_par2ser_harness #(.DDR(1'b0), .RATIO(3))  h_s3  (.clk(clk), .checks(c1), .fails(f1), .done(d1));
  tb_par2ser_harness #(.DDR(1'b0), .RATIO(8))  h_s8  (.clk(clk), .checks(c2), .fails(f2), .done(d2));
  tb_par2ser_harness #(.DDR(1'b1), .RATIO(4))  h_d4  (.clk(clk), .checks(c3), .fails(f3), .done(d3));
  tb_par2ser_harness #(.DDR(1'b1), .RATIO(6))  h_d6  (.clk(clk), .checks(c4), .fails(f4), .done(d4));
  tb_par2ser_harness #(.DDR(1'b1), .RATIO(10)) h_d10 (.clk(clk), .checks(c5), .fails(f5), .done(d5));

  initial begin
    int cyc;
    int tot_c;
    int tot_f;
    cyc = 0;
    while (!(d0 && d1 && d2 && d3 && d4 && d5) && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    @(negedge clk);
    tot_c = c0 + c1 + c2 + c3 + c4 + c5;
    tot_f = f0 + f1 + f2 + f3 + f4 + f5;
    if (!(d0 && d1 && d2 && d3 && d4 && d5)) begin
      tot_c = tot_c + 1;
      tot_f = tot_f + 1;
      $display("FAIL watchdog: got unfinished run expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", tot_c, tot_f);
    $finish;
  end
endmodule